// File: doc/BRIEF.md
# Hot-swap bus link controller

This block is the digital control core of a two-wire bus buffer that may be plugged into a live backplane. It watches the supply-good flag, an enable input and the sampled levels of the four bus lines: data and clock on the card side and on the backplane side. It keeps the two sides apart until joining them is safe. While it waits to join, it asks for the lines to be precharged. Once the sides are joined, it mirrors a LOW from either side of a line pair onto the other side through a pull-down enable.

After supply-good and enable are both present, a fixed-length settling phase runs with precharge active. Detection is armed only when that phase ends. The sides are then joined after all four lines have stayed HIGH for a programmable idle time. They are also joined when a STOP condition is seen on the card side while every line is HIGH. When enable or supply-good drops, the block returns to the isolated state on the next clock edge and every pull-down is released at once.

Every bus input passes through a synchronizer chain. To keep a pair from latching itself LOW, a side that the block has just stopped pulling is ignored for a short blanking window. All timing inputs are sampled synchronously to `clk`.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: While `pwr_good` is 0, and one clock after it falls, `link_on`, `prechg_en` and all four pull-down outputs are 0. They are also 0 under reset.
- R2: When `enable` is 0 at a clock edge, `link_on` and all four pull-down outputs are 0 after that edge, whatever the prior state.
- R3: With `pwr_good` and `enable` both 1 in the isolated state, `prechg_en` is 1 after the next edge. A settling phase of INIT_CYCLES edges follows, during which no join can happen.
- R4: With all lines HIGH throughout, `link_on` rises INIT_CYCLES+IDLE_CYCLES+1 edges after enable is first seen high, counting that edge as the first. Defaults: 8+20+1 = 29.
- R5: Any LOW on any of the four lines during the armed phase restarts the idle count from zero.
- R6: In the armed phase, a rising card-side data line (bit index 0 of the internal line vector) while the card-side clock is HIGH and all lines are HIGH sets `link_on` SYNC_STAGES+1 edges after the release.
- R7: A STOP-like data rise during the settling phase is ignored, and the join then waits for the full idle time.
- R8: `prechg_en` falls on the same edge on which `link_on` rises, and is 1 throughout the settling and armed phases.
- R9: When joined, an external LOW on one side of a pair asserts the pull-down of the other side SYNC_STAGES+1 edges later. The same latency applies when the LOW is released.
- R10: The data pair and the clock pair are handled independently. A LOW on one never drives the other.
- R11: While both sides of a pair are held LOW externally and the original side is released, the pull-down moves to the released side after the blanking window. The pair is freed only when the last external driver lets go.
- R12: After the block stops pulling a side, that side is ignored for SYNC_STAGES+1 edges, so the pair never latches LOW on the block's own drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply is within range |
| enable | input | 1 | Enable, low forces isolation |
| card_sda_i | input | 1 | Sampled card-side data line level |
| card_scl_i | input | 1 | Sampled card-side clock line level |
| bp_sda_i | input | 1 | Sampled backplane-side data line level |
| bp_scl_i | input | 1 | Sampled backplane-side clock line level |
| link_on | output | 1 | Sides joined |
| prechg_en | output | 1 | Precharge request |
| card_sda_pd | output | 1 | Pull card-side data LOW |
| card_scl_pd | output | 1 | Pull card-side clock LOW |
| bp_sda_pd | output | 1 | Pull backplane-side data LOW |
| bp_scl_pd | output | 1 | Pull backplane-side clock LOW |

## Verification
The assertions check on every cycle that supply loss or a low enable isolates the block on the next edge. They also check that a join happens only from the armed phase with all lines HIGH, that precharge hands over to the link on the same edge, and that a pull-down starts only because the opposite side is LOW and holds while that side stays LOW. Exact cycle counts cannot be seen from one cycle's view, so only the bench scenarios show them: the settling and idle lengths, the restart of the idle count, the STOP path being ignored during settling, the blanking window, and the hand-over of a stretched clock between sides.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
   typedef enum logic [1:0] {
      SQ_OFF    = 2'd0,
      SQ_INIT   = 2'd1,
      SQ_ARMED  = 2'd2,
      SQ_LINKED = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      LN_IDLE = 2'd0,
      LN_A2B  = 2'd1,
      LN_B2A  = 2'd2
   } lane_state_e;

   localparam int NUM_LINES    = 4;
   localparam int NUM_LANES    = 2;
   localparam int IDX_CARD_SDA = 0;
   localparam int IDX_CARD_SCL = 1;
   localparam int IDX_BP_SDA   = 2;
   localparam int IDX_BP_SCL   = 3;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '1;
      else        chain[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '1;
         else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/hsb_seq.sv
module hsb_seq
   import hsb_pkg::*;
#(
   parameter int INIT_CYCLES = 8,
   parameter int IDLE_CYCLES = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pwr_good,
   input  logic                 enable,
   input  logic [NUM_LINES-1:0] bus_hi,
   output logic                 link_on,
   output logic                 prechg_en
);
   localparam int MAXC = (INIT_CYCLES > IDLE_CYCLES) ? INIT_CYCLES : IDLE_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYCLES - 1);
   localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYCLES - 1);

   seq_state_e    state, nxt;
   logic [CW-1:0] init_cnt, idle_cnt;
   logic          sda_prev;
   logic          all_hi, stop_seen, idle_done, init_done;

   assign all_hi    = &bus_hi;
   assign init_done = (init_cnt == INIT_LAST);
   assign idle_done = all_hi && (idle_cnt == IDLE_LAST);
   assign stop_seen = (state == SQ_ARMED) && !sda_prev && all_hi
                      && bus_hi[IDX_CARD_SDA] && bus_hi[IDX_CARD_SCL];

   always_comb begin
      nxt = state;
      if (!pwr_good || !enable) begin
         nxt = SQ_OFF;
      end else begin
         case (state)
            SQ_OFF:    nxt = SQ_INIT;
            SQ_INIT:   if (init_done) nxt = SQ_ARMED;
            SQ_ARMED:  if (idle_done || stop_seen) nxt = SQ_LINKED;
            SQ_LINKED: nxt = SQ_LINKED;
            default:   nxt = SQ_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_OFF;
         init_cnt <= '0;
         idle_cnt <= '0;
         sda_prev <= 1'b1;
      end else begin
         state    <= nxt;
         init_cnt <= (state == SQ_INIT && nxt == SQ_INIT) ? init_cnt + 1'b1 : '0;
         idle_cnt <= (state == SQ_ARMED && all_hi) ? idle_cnt + 1'b1 : '0;
         sda_prev <= (state == SQ_ARMED) ? bus_hi[IDX_CARD_SDA] : 1'b1;
      end
   end

   assign link_on   = (state == SQ_LINKED);
   assign prechg_en = (state == SQ_INIT) || (state == SQ_ARMED);

   a_r1_pwr_off: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (!link_on && !prechg_en));
   a_r2_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!link_on && !prechg_en));
   a_r3_prechg_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_on && !prechg_en && pwr_good && enable) |=> prechg_en);
   a_r8_prechg_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_on) |-> ($past(prechg_en) && !prechg_en));
   a_r6_join_all_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_on) |-> $past(&bus_hi));
   a_r7_join_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_on) |-> $past(state == SQ_ARMED));
endmodule

// File: rtl/hsb_lane.sv
module hsb_lane
   import hsb_pkg::*;
#(
   parameter int BLANK_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic a_hi,
   input  logic b_hi,
   output logic drive_a,
   output logic drive_b
);
   localparam int BW = $clog2(BLANK_CYCLES + 1);
   localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYCLES);

   lane_state_e   st, st_n;
   logic [BW-1:0] blank_a, blank_b;
   logic          load_a, load_b, a_low_seen, b_low_seen;

   assign a_low_seen = !a_hi && (blank_a == '0);
   assign b_low_seen = !b_hi && (blank_b == '0);

   always_comb begin
      st_n   = st;
      load_a = 1'b0;
      load_b = 1'b0;
      case (st)
         LN_IDLE: begin
            if (a_low_seen)      st_n = LN_A2B;
            else if (b_low_seen) st_n = LN_B2A;
         end
         LN_A2B: if (a_hi) begin st_n = LN_IDLE; load_b = 1'b1; end
         LN_B2A: if (b_hi) begin st_n = LN_IDLE; load_a = 1'b1; end
         default: st_n = LN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= LN_IDLE;
         blank_a <= '0;
         blank_b <= '0;
      end else if (!active) begin
         st      <= LN_IDLE;
         blank_a <= '0;
         blank_b <= '0;
      end else begin
         st      <= st_n;
         blank_a <= load_a ? BLANK_LOAD : ((blank_a != '0) ? blank_a - 1'b1 : '0);
         blank_b <= load_b ? BLANK_LOAD : ((blank_b != '0) ? blank_b - 1'b1 : '0);
      end
   end

   assign drive_a = (st == LN_B2A);
   assign drive_b = (st == LN_A2B);

   a_r9_drive_b_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_b) |-> $past(!a_hi));
   a_r9_drive_a_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_a) |-> $past(!b_hi));
   a_r11_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
      (active && drive_b && !a_hi) |=> (drive_b || !active));
   a_r11_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
      (active && drive_a && !b_hi) |=> (drive_a || !active));
endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl
   import hsb_pkg::*;
#(
   parameter int INIT_CYCLES = 8,
   parameter int IDLE_CYCLES = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic enable,
   input  logic card_sda_i,
   input  logic card_scl_i,
   input  logic bp_sda_i,
   input  logic bp_scl_i,
   output logic link_on,
   output logic prechg_en,
   output logic card_sda_pd,
   output logic card_scl_pd,
   output logic bp_sda_pd,
   output logic bp_scl_pd
);
   localparam int BLANK_CYCLES = SYNC_STAGES + 1;

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least 1");
   end
   if (IDLE_CYCLES < 2) begin : g_bad_idle
      $error("IDLE_CYCLES must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] raw_lines, sync_lines;
   logic [NUM_LANES-1:0] pd_card, pd_bp;

   assign raw_lines[IDX_CARD_SDA] = card_sda_i;
   assign raw_lines[IDX_CARD_SCL] = card_scl_i;
   assign raw_lines[IDX_BP_SDA]   = bp_sda_i;
   assign raw_lines[IDX_BP_SCL]   = bp_scl_i;

   hsb_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines),
      .dout (sync_lines)
   );

   hsb_seq #(.INIT_CYCLES(INIT_CYCLES), .IDLE_CYCLES(IDLE_CYCLES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_good (pwr_good),
      .enable   (enable),
      .bus_hi   (sync_lines),
      .link_on  (link_on),
      .prechg_en(prechg_en)
   );

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic drv_card, drv_bp;
      hsb_lane #(.BLANK_CYCLES(BLANK_CYCLES)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .active (link_on),
         .a_hi   (sync_lines[IDX_CARD_SDA + l]),
         .b_hi   (sync_lines[IDX_BP_SDA + l]),
         .drive_a(drv_card),
         .drive_b(drv_bp)
      );
      assign pd_card[l] = drv_card && link_on;
      assign pd_bp[l]   = drv_bp && link_on;
   end

   assign card_sda_pd = pd_card[0];
   assign card_scl_pd = pd_card[1];
   assign bp_sda_pd   = pd_bp[0];
   assign bp_scl_pd   = pd_bp[1];

   a_r2_pd_released: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !(card_sda_pd || card_scl_pd || bp_sda_pd || bp_scl_pd));
   a_r10_no_self_pair: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_sda_pd && bp_sda_pd) && !(card_scl_pd && bp_scl_pd));
endmodule

// File: tb/tb_hotswap_link_ctrl.sv
`timescale 1ns/1ps
module tb_hotswap_link_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b0;
   logic enable = 1'b0;
   logic [3:0] ext_low = 4'b0000; // 0 card SDA, 1 card SCL, 2 bp SDA, 3 bp SCL
   logic card_sda_i, card_scl_i, bp_sda_i, bp_scl_i;
   logic link_on, prechg_en, card_sda_pd, card_scl_pd, bp_sda_pd, bp_scl_pd;

   always #2 clk = ~clk;

   // wired-AND bus model: a line is LOW if anybody pulls it
   assign card_sda_i = !(ext_low[0] || card_sda_pd);
   assign card_scl_i = !(ext_low[1] || card_scl_pd);
   assign bp_sda_i   = !(ext_low[2] || bp_sda_pd);
   assign bp_scl_i   = !(ext_low[3] || bp_scl_pd);

   hotswap_link_ctrl #(.INIT_CYCLES(8), .IDLE_CYCLES(20), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .enable(enable),
      .card_sda_i(card_sda_i), .card_scl_i(card_scl_i),
      .bp_sda_i(bp_sda_i), .bp_scl_i(bp_scl_i),
      .link_on(link_on), .prechg_en(prechg_en),
      .card_sda_pd(card_sda_pd), .card_scl_pd(card_scl_pd),
      .bp_sda_pd(bp_sda_pd), .bp_scl_pd(bp_scl_pd)
   );

   // observed vector: {link, prechg, card_sda_pd, card_scl_pd, bp_sda_pd, bp_scl_pd}
   localparam logic [5:0] M_LINK = 6'b100000, M_PRE = 6'b010000;
   localparam logic [5:0] M_CSDA = 6'b001000, M_CSCL = 6'b000100;
   localparam logic [5:0] M_BSDA = 6'b000010, M_BSCL = 6'b000001;
   localparam logic [5:0] M_ALL = 6'b111111, M_PDS = 6'b001111;

   typedef struct {
      int         cyc;
      logic [5:0] mask;
      logic [5:0] val;
      string      req;
   } exp_t;

   exp_t exp_q[$];
   int cyc = 0;
   int checks = 0;
   int errors = 0;
   logic [5:0] obs;
   assign obs = {link_on, prechg_en, card_sda_pd, card_scl_pd, bp_sda_pd, bp_scl_pd};

   task automatic expect_at(input int d, input logic [5:0] mask,
                            input logic [5:0] val, input string req);
      exp_t e;
      e.cyc = cyc + d; e.mask = mask; e.val = val; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compare scheduled expectations one step after each edge
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         #1;
         for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].cyc == cyc) begin
               checks++;
               if ((obs & exp_q[i].mask) !== (exp_q[i].val & exp_q[i].mask)) begin
                  errors++;
                  $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                           exp_q[i].req, cyc, obs, exp_q[i].val, exp_q[i].mask);
               end
               exp_q.delete(i);
            end
         end
      end
   end

   // watchdog
   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait_n(1);
      expect_at(1, M_ALL, 6'b0, "R1 reset");
      wait_n(3);
      rst_n = 1'b1;
      enable = 1'b1;
      // R1: supply not good keeps everything off
      expect_at(2, M_ALL, 6'b0, "R1 power-up");
      expect_at(8, M_ALL, 6'b0, "R1 power-up");
      wait_n(10);

      // R3/R4/R8: supply good, idle join
      pwr_good = 1'b1;
      expect_at(1, M_LINK | M_PRE, M_PRE, "R3 precharge start");
      expect_at(28, M_LINK | M_PRE, M_PRE, "R4 not yet joined");
      expect_at(29, M_LINK | M_PRE, M_LINK, "R4 R8 join and precharge off");
      wait_n(32);

      // R9/R10: card SDA low mirrored to backplane only
      ext_low[0] = 1'b1;
      expect_at(2, M_BSDA, 6'b0, "R9 latency");
      expect_at(3, M_PDS, M_BSDA, "R9 R10 card SDA mirrored");
      wait_n(6);
      ext_low[0] = 1'b0;
      expect_at(2, M_BSDA, M_BSDA, "R9 release latency");
      expect_at(3, M_BSDA, 6'b0, "R9 release");
      expect_at(8, M_PDS, 6'b0, "R12 no self latch");
      wait_n(10);

      // R9/R10: backplane SCL low mirrored to card
      ext_low[3] = 1'b1;
      expect_at(3, M_PDS, M_CSCL, "R9 R10 bp SCL mirrored");
      wait_n(5);
      ext_low[3] = 1'b0;
      expect_at(3, M_PDS, 6'b0, "R9 release");
      wait_n(10);

      // R11: clock stretched on both sides, hand-over
      ext_low[1] = 1'b1;
      expect_at(3, M_PDS, M_BSCL, "R11 first side");
      wait_n(5);
      ext_low[3] = 1'b1;
      expect_at(4, M_PDS, M_BSCL, "R11 both held");
      wait_n(6);
      ext_low[1] = 1'b0;
      expect_at(3, M_BSCL, 6'b0, "R11 drive dropped");
      expect_at(6, M_CSCL, 6'b0, "R12 blanking");
      expect_at(7, M_PDS, M_CSCL, "R11 hand-over");
      expect_at(12, M_PDS, M_CSCL, "R11 held by bp");
      wait_n(14);
      ext_low[3] = 1'b0;
      expect_at(2, M_CSCL, M_CSCL, "R11 still held");
      expect_at(3, M_CSCL, 6'b0, "R11 freed");
      expect_at(10, M_PDS, 6'b0, "R12 no self latch");
      wait_n(12);

      // R2: drop enable while driving
      ext_low[0] = 1'b1;
      wait_n(5);
      enable = 1'b0;
      expect_at(1, M_ALL, 6'b0, "R2 enable off");
      wait_n(2);
      ext_low[0] = 1'b0;
      wait_n(3);

      // R6: STOP join after arming
      ext_low[0] = 1'b1;
      wait_n(2);
      enable = 1'b1;
      expect_at(1, M_LINK | M_PRE, M_PRE, "R3 restart");
      wait_n(15);
      ext_low[0] = 1'b0;
      expect_at(2, M_LINK | M_PRE, M_PRE, "R6 before stop seen");
      expect_at(3, M_LINK | M_PRE, M_LINK, "R6 stop join");
      wait_n(6);

      // R7: STOP during settling ignored
      enable = 1'b0;
      wait_n(3);
      ext_low[0] = 1'b1;
      wait_n(2);
      enable = 1'b1;
      wait_n(3);
      ext_low[0] = 1'b0;
      expect_at(10, M_LINK, 6'b0, "R7 no early join");
      expect_at(25, M_LINK, 6'b0, "R7 waits full idle");
      expect_at(26, M_LINK | M_PRE, M_LINK, "R7 idle join");
      wait_n(30);

      // R5: glitch restarts idle count
      enable = 1'b0;
      wait_n(3);
      enable = 1'b1;
      wait_n(15);
      ext_low[3] = 1'b1;
      wait_n(1);
      ext_low[3] = 1'b0;
      expect_at(13, M_LINK, 6'b0, "R5 restarted");
      expect_at(21, M_LINK, 6'b0, "R5 restarted");
      expect_at(22, M_LINK, M_LINK, "R5 join after restart");
      wait_n(25);

      // R1: supply loss while joined
      pwr_good = 1'b0;
      expect_at(1, M_ALL, 6'b0, "R1 supply lost");
      wait_n(4);

      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule